// File: doc/BRIEF.md
# Prioritized Memory Chip-Select Decoder

This block turns a microcontroller bus address and its two read strobes into chip selects for three classes of memory: eight primary flash sectors, four secondary flash sectors and one SRAM. Every select owns an inclusive address window given by a base and a limit on the configuration inputs. Windows may overlap across classes. The overlap is then resolved by a fixed ranking: SRAM beats secondary flash, and secondary flash beats primary flash.

A small space-assignment register decides which strobe each memory class answers to. The program-fetch strobe and the data-read strobe can each be enabled per class, so a memory can sit in program space, in data space or in both. The register loads a configured value on reset. The microcontroller can rewrite it at one fixed control address, so memories can be moved between spaces while running.

The select outputs are combinational from the address, the strobes and the register. A configuration-error output flags window tables that break the placement rules.

Top module: `mcs_decoder`

## Requirements
- R1: A window is active when its limit is greater than or equal to its base. An active window matches every address from its base to its limit inclusive. A window whose limit is below its base never matches and is never an error. Window index 0..7 is primary sector 0..7, index 8..11 is secondary sector 0..3, and index 12 is the SRAM.
- R2: No more than one of the thirteen select outputs is high at any moment.
- R3: When windows of different classes both match, the SRAM window wins over secondary flash, and secondary flash wins over primary flash. For example, with primary 0 at 8000h–BFFFh, secondary 0 at 8000h–9FFFh and SRAM at 8000h–87FFh: 8000h–87FFh selects the SRAM, 8800h–9FFFh selects secondary 0, and A000h–BFFFh selects primary 0.
- R4: When two active windows of the same flash class overlap, cfg_err is high. An address in the shared range selects the lower-indexed sector.
- R5: cfg_err is high when an active window spans more bytes than its physical sector. The limits are 16384 bytes for primary, 8192 for secondary and 2048 for the SRAM. A window of exactly that size does not raise the flag.
- R6: While prog_stb and data_stb are both low, every select output is low.
- R7: Space register bit meanings: bit 0 lets the SRAM answer the program strobe, bit 1 lets secondary flash answer the program strobe, bit 2 lets primary flash answer the program strobe, bit 3 lets secondary flash answer the data strobe, and bit 4 lets primary flash answer the data strobe. The SRAM always answers the data strobe.
- R8: If the winning class is not enabled for the active strobe, all selects stay low. There is no fall-through to a lower class.
- R9: After reset the space register holds 0Ch, which puts primary flash in program space and secondary flash in data space.
- R10: A write with map_wr high and bus_addr equal to 00B0h loads wr_data[4:0] at the clock edge and governs decoding from the next cycle on. A write at any other address leaves the register unchanged.
- R11: rd_data shows {3'b000, register} while bus_addr is 00B0h, and 00h otherwise.
- R12: With the register at 14h, primary flash answers both strobes (combined space), and secondary flash answers neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| prog_stb | input | 1 | Program-fetch strobe, active high |
| data_stb | input | 1 | Data-read strobe, active high |
| map_wr | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| win_base | input | 208 | Window bases, 16 bits per window, window i at bits [16i+15:16i] |
| win_limit | input | 208 | Window limits, same packing as win_base |
| rd_data | output | 8 | Register read data |
| pri_sel | output | 8 | Primary flash sector selects |
| sec_sel | output | 4 | Secondary flash sector selects |
| sram_sel | output | 1 | SRAM select |
| cfg_err | output | 1 | Window table breaks a placement rule |

## Verification
The only state is the space register. If it is corrupted, the next strobed access to a memory whose enable bit flipped shows a missing or unexpected select in that same cycle. A read at 00B0h exposes the corrupted value at once. A wrong ranking or a wrong within-class choice shows up as the wrong select line in the very cycle the address lands in an overlap. The bench therefore probes each edge of the overlapping example windows under both strobes, and under several register values.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int ADDR_W    = 16;
    localparam int NPRI      = 8;
    localparam int NSEC      = 4;
    localparam int PRI_BYTES = 16384;
    localparam int SEC_BYTES = 8192;
    localparam int RAM_BYTES = 2048;

    // Space assignment register, bit 4 down to bit 0
    typedef struct packed {
        logic pri_data;
        logic sec_data;
        logic pri_prog;
        logic sec_prog;
        logic ram_prog;
    } space_map_t;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_PRI,
        CLS_SEC,
        CLS_RAM
    } mem_class_t;

    function automatic logic win_active(input logic [ADDR_W-1:0] base,
                                        input logic [ADDR_W-1:0] limit);
        return limit >= base;
    endfunction

    function automatic logic ranges_overlap(input logic [ADDR_W-1:0] b0,
                                            input logic [ADDR_W-1:0] l0,
                                            input logic [ADDR_W-1:0] b1,
                                            input logic [ADDR_W-1:0] l1);
        return win_active(b0, l0) && win_active(b1, l1) && (b0 <= l1) && (b1 <= l0);
    endfunction

endpackage

// File: rtl/mcs_window_match.sv
module mcs_window_match
    import mcs_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int MAX_BYTES = PRI_BYTES
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          hit,
    output logic          too_big
);
    localparam logic [AW:0] MAXV = (AW+1)'(MAX_BYTES);
    localparam logic [AW:0] ONE  = (AW+1)'(1);

    logic          active;
    logic [AW:0]   span;

    always_comb begin
        active  = (limit >= base);
        span    = {1'b0, limit} - {1'b0, base} + ONE;
        hit     = active && (addr >= base) && (addr <= limit);
        too_big = active && (span > MAXV);
    end
endmodule

// File: rtl/mcs_overlap_check.sv
module mcs_overlap_check
    import mcs_pkg::*;
#(
    parameter int N  = NPRI,
    parameter int AW = ADDR_W
) (
    input  logic [N-1:0][AW-1:0] base,
    input  logic [N-1:0][AW-1:0] limit,
    output logic                 overlap
);
    always_comb begin
        overlap = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (ranges_overlap(base[i], limit[i], base[j], limit[j]))
                    overlap = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcs_space_reg.sv
module mcs_space_reg
    import mcs_pkg::*;
#(
    parameter int              AW        = ADDR_W,
    parameter logic [AW-1:0]   MAP_ADDR  = 16'h00B0,
    parameter logic [4:0]      MAP_RESET = 5'h0C
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output space_map_t    map_q,
    output logic [7:0]    rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            map_q <= space_map_t'(MAP_RESET);
        else if (wr_en && addr == MAP_ADDR)
            map_q <= space_map_t'(wdata[4:0]);
    end

    always_comb rdata = (addr == MAP_ADDR) ? {3'b000, map_q} : 8'h00;
endmodule

// File: rtl/mcs_resolver.sv
module mcs_resolver
    import mcs_pkg::*;
#(
    parameter int NP = NPRI,
    parameter int NS = NSEC
) (
    input  logic [NP-1:0] pri_hit,
    input  logic [NS-1:0] sec_hit,
    input  logic          ram_hit,
    input  logic          prog,
    input  logic          data,
    input  space_map_t    map,
    output logic [NP-1:0] pri_sel,
    output logic [NS-1:0] sec_sel,
    output logic          ram_sel
);
    logic [NP-1:0] pri_one;
    logic [NS-1:0] sec_one;
    mem_class_t    cls;
    logic          granted;

    // lowest index wins inside a class
    always_comb begin
        pri_one = '0;
        for (int i = NP - 1; i >= 0; i--)
            if (pri_hit[i]) pri_one = NP'(1) << i;
        sec_one = '0;
        for (int i = NS - 1; i >= 0; i--)
            if (sec_hit[i]) sec_one = NS'(1) << i;
    end

    always_comb begin
        if (ram_hit)       cls = CLS_RAM;
        else if (|sec_hit) cls = CLS_SEC;
        else if (|pri_hit) cls = CLS_PRI;
        else               cls = CLS_NONE;

        unique case (cls)
            CLS_RAM: granted = data || (prog && map.ram_prog);
            CLS_SEC: granted = (data && map.sec_data) || (prog && map.sec_prog);
            CLS_PRI: granted = (data && map.pri_data) || (prog && map.pri_prog);
            default: granted = 1'b0;
        endcase

        ram_sel = granted && (cls == CLS_RAM);
        sec_sel = (granted && cls == CLS_SEC) ? sec_one : '0;
        pri_sel = (granted && cls == CLS_PRI) ? pri_one : '0;
    end
endmodule

// File: rtl/mcs_decoder.sv
module mcs_decoder
    import mcs_pkg::*;
#(
    parameter int                NP        = NPRI,
    parameter int                NS        = NSEC,
    parameter int                AW        = ADDR_W,
    parameter logic [AW-1:0]     MAP_ADDR  = 16'h00B0,
    parameter logic [4:0]        MAP_RESET = 5'h0C,
    localparam int               NWIN      = NP + NS + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 prog_stb,
    input  logic                 data_stb,
    input  logic                 map_wr,
    input  logic [7:0]           wr_data,
    input  logic [NWIN*AW-1:0]   win_base,
    input  logic [NWIN*AW-1:0]   win_limit,
    output logic [7:0]           rd_data,
    output logic [NP-1:0]        pri_sel,
    output logic [NS-1:0]        sec_sel,
    output logic                 sram_sel,
    output logic                 cfg_err
);
    localparam int RAM_IDX = NP + NS;

    space_map_t      map_q;
    logic [NWIN-1:0] hit;
    logic [NWIN-1:0] too_big;
    logic            pri_ovl;
    logic            sec_ovl;
    logic [NP-1:0][AW-1:0] pri_base, pri_limit;
    logic [NS-1:0][AW-1:0] sec_base, sec_limit;

    mcs_space_reg #(.AW(AW), .MAP_ADDR(MAP_ADDR), .MAP_RESET(MAP_RESET)) u_space (
        .clk(clk), .rst(rst), .wr_en(map_wr), .addr(bus_addr),
        .wdata(wr_data), .map_q(map_q), .rdata(rd_data)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam int LIM = (w < NP) ? PRI_BYTES : ((w < RAM_IDX) ? SEC_BYTES : RAM_BYTES);
        mcs_window_match #(.AW(AW), .MAX_BYTES(LIM)) u_match (
            .addr(bus_addr),
            .base(win_base[w*AW +: AW]),
            .limit(win_limit[w*AW +: AW]),
            .hit(hit[w]),
            .too_big(too_big[w])
        );
    end

    for (genvar p = 0; p < NP; p++) begin : g_pri
        assign pri_base[p]  = win_base[p*AW +: AW];
        assign pri_limit[p] = win_limit[p*AW +: AW];
    end
    for (genvar s = 0; s < NS; s++) begin : g_sec
        assign sec_base[s]  = win_base[(NP+s)*AW +: AW];
        assign sec_limit[s] = win_limit[(NP+s)*AW +: AW];
    end

    mcs_overlap_check #(.N(NP), .AW(AW)) u_pri_ovl (
        .base(pri_base), .limit(pri_limit), .overlap(pri_ovl)
    );
    mcs_overlap_check #(.N(NS), .AW(AW)) u_sec_ovl (
        .base(sec_base), .limit(sec_limit), .overlap(sec_ovl)
    );

    assign cfg_err = pri_ovl || sec_ovl || (|too_big);

    mcs_resolver #(.NP(NP), .NS(NS)) u_resolve (
        .pri_hit(hit[NP-1:0]),
        .sec_hit(hit[RAM_IDX-1:NP]),
        .ram_hit(hit[RAM_IDX]),
        .prog(prog_stb),
        .data(data_stb),
        .map(map_q),
        .pri_sel(pri_sel),
        .sec_sel(sec_sel),
        .ram_sel(sram_sel)
    );
endmodule

// File: rtl/mcs_decoder_chk.sv
module mcs_decoder_chk #(
    parameter int          NP        = 8,
    parameter int          NS        = 4,
    parameter int          AW        = 16,
    parameter logic [AW-1:0] MAP_ADDR  = 16'h00B0,
    parameter logic [4:0]  MAP_RESET = 5'h0C
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          prog_stb,
    input logic          data_stb,
    input logic          map_wr,
    input logic [7:0]    wr_data,
    input logic [7:0]    rd_data,
    input logic [NP-1:0] pri_sel,
    input logic [NS-1:0] sec_sel,
    input logic          sram_sel,
    input logic [4:0]    map_q
);
    a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pri_sel, sec_sel, sram_sel}));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!prog_stb && !data_stb) |-> ({pri_sel, sec_sel, sram_sel} == '0));

    a_r7_pri_gated: assert property (@(posedge clk) disable iff (rst)
        (|pri_sel) |-> ((prog_stb && map_q[2]) || (data_stb && map_q[4])));

    a_r7_sec_gated: assert property (@(posedge clk) disable iff (rst)
        (|sec_sel) |-> ((prog_stb && map_q[1]) || (data_stb && map_q[3])));

    a_r9_reset_value: assert property (@(posedge clk)
        rst |=> (map_q == MAP_RESET));

    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        (map_wr && bus_addr == MAP_ADDR) |=> (map_q == $past(wr_data[4:0])));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !(map_wr && bus_addr == MAP_ADDR) |=> $stable(map_q));

    a_r11_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == MAP_ADDR) |-> (rd_data == {3'b000, map_q}));
endmodule

bind mcs_decoder mcs_decoder_chk #(
    .NP(NP), .NS(NS), .AW(AW), .MAP_ADDR(MAP_ADDR), .MAP_RESET(MAP_RESET)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .prog_stb(prog_stb),
    .data_stb(data_stb), .map_wr(map_wr), .wr_data(wr_data),
    .rd_data(rd_data), .pri_sel(pri_sel), .sec_sel(sec_sel),
    .sram_sel(sram_sel), .map_q(map_q)
);

// File: tb/test_mcs_decoder.sv
`timescale 1ns/1ps
module test_mcs_decoder;
    localparam int NW = 13;
    localparam logic [15:0] MAPA = 16'h00B0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        prog_stb = 1'b0;
    logic        data_stb = 1'b0;
    logic        map_wr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [NW*16-1:0] win_base;
    logic [NW*16-1:0] win_limit;
    logic [7:0]  rd_data;
    logic [7:0]  pri_sel;
    logic [3:0]  sec_sel;
    logic        sram_sel;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mcs_decoder i_mcs_decoder (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .prog_stb(prog_stb),
        .data_stb(data_stb), .map_wr(map_wr), .wr_data(wr_data),
        .win_base(win_base), .win_limit(win_limit), .rd_data(rd_data),
        .pri_sel(pri_sel), .sec_sel(sec_sel), .sram_sel(sram_sel),
        .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_win(input int idx, input logic [15:0] b, input logic [15:0] l);
        win_base[idx*16 +: 16]  = b;
        win_limit[idx*16 +: 16] = l;
    endtask

    // selects packed as {pri[7:0], sec[3:0], sram}
    task automatic probe(input string req, input logic [15:0] a, input logic p,
                         input logic d, input logic [12:0] exp);
        @(negedge clk);
        bus_addr = a; prog_stb = p; data_stb = d;
        #1;
        check(req, {19'd0, pri_sel, sec_sel, sram_sel}, {19'd0, exp});
        prog_stb = 0; data_stb = 0;
    endtask

    task automatic write_map(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; wr_data = v; map_wr = 1;
        @(negedge clk);
        map_wr = 0;
    endtask

    task automatic read_map(input string req, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, {24'd0, rd_data}, {24'd0, exp});
    endtask

    task automatic base_table();
        for (int i = 0; i < NW; i++) set_win(i, 16'hFFFF, 16'h0000);
        set_win(0, 16'h8000, 16'hBFFF);
        set_win(1, 16'hC000, 16'hFFFF);
        set_win(3, 16'h4000, 16'h7FFF);
        set_win(8, 16'h8000, 16'h9FFF);
        set_win(12, 16'h8000, 16'h87FF);
    endtask

    localparam logic [12:0] NONE = 13'd0;
    localparam logic [12:0] RAM  = 13'd1;
    function automatic logic [12:0] SEC(input int i); return 13'(1 << (1 + i)); endfunction
    function automatic logic [12:0] PRI(input int i); return 13'(1 << (5 + i)); endfunction

    task automatic t_reset();
        read_map("R9 reset value", MAPA, 8'h0C);
        read_map("R11 other address reads zero", 16'h00B1, 8'h00);
        check("R5 exact-size windows no error", {31'd0, cfg_err}, 32'd0);
        probe("R6 no strobe", 16'h8100, 0, 0, NONE);
    endtask

    task automatic t_separate();
        probe("R3 sram on data", 16'h8100, 0, 1, RAM);
        probe("R3 sec0 on data", 16'h9000, 0, 1, SEC(0));
        probe("R8 primary not in data space", 16'hA000, 0, 1, NONE);
        probe("R7 primary on program", 16'hA000, 1, 0, PRI(0));
        probe("R8 sram winner not in program space", 16'h8100, 1, 0, NONE);
        probe("R8 sec winner not in program space", 16'h9000, 1, 0, NONE);
    endtask

    task automatic t_boundaries();
        write_map(MAPA, 8'h1F);
        read_map("R10 write lands", MAPA, 8'h1F);
        probe("R3 low edge sram", 16'h8000, 0, 1, RAM);
        probe("R3 top sram", 16'h87FF, 0, 1, RAM);
        probe("R3 sec above sram", 16'h8800, 0, 1, SEC(0));
        probe("R3 top sec", 16'h9FFF, 0, 1, SEC(0));
        probe("R3 primary above sec", 16'hA000, 0, 1, PRI(0));
        probe("R1 top primary 0", 16'hBFFF, 1, 0, PRI(0));
        probe("R1 primary 1 base", 16'hC000, 0, 1, PRI(1));
        probe("R1 primary 3 top", 16'h7FFF, 1, 0, PRI(3));
        probe("R1 unmapped", 16'h0100, 0, 1, NONE);
        probe("R7 sram on program bit0", 16'h8100, 1, 0, RAM);
        probe("R7 sec on program bit1", 16'h9000, 1, 0, SEC(0));
    endtask

    task automatic t_combined();
        write_map(MAPA, 8'h14);
        probe("R12 primary via program", 16'hA000, 1, 0, PRI(0));
        probe("R12 primary via data", 16'hA000, 0, 1, PRI(0));
        probe("R12 sec off both", 16'h9000, 1, 1, NONE);
        write_map(16'h00B2, 8'h03);
        read_map("R10 wrong address ignored", MAPA, 8'h14);
        write_map(MAPA, 8'h0C);
        read_map("R11 readback", MAPA, 8'h0C);
    endtask

    task automatic t_overlap();
        set_win(9, 16'h9000, 16'h9FFF);
        #1;
        check("R4 sec overlap flag", {31'd0, cfg_err}, 32'd1);
        probe("R4 lower sec index wins", 16'h9800, 0, 1, SEC(0));
        base_table();
        set_win(5, 16'hA000, 16'hA0FF);
        #1;
        check("R4 pri overlap flag", {31'd0, cfg_err}, 32'd1);
        probe("R4 lower pri index wins", 16'hA010, 1, 0, PRI(0));
        base_table();
        set_win(2, 16'h0000, 16'h7FFF);
        #1;
        check("R5 oversize primary", {31'd0, cfg_err}, 32'd1);
        base_table();
        set_win(12, 16'h8000, 16'h8800);
        #1;
        check("R5 oversize sram", {31'd0, cfg_err}, 32'd1);
        base_table();
        #1;
        check("R5 restored table clean", {31'd0, cfg_err}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        base_table();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_separate();
        t_boundaries();
        t_combined();
        t_overlap();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule